// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache that sits between a processor and a slower memory. It holds 32 lines of 32 bytes each, for 1 KB in all. Each line keeps a valid flag and a tag. The processor presents one word-aligned request at a time and holds it steady until the stall output drops. A read that hits returns its word in the same cycle. A read that misses stalls the processor while the cache fetches the whole line from memory as eight word reads.

Every store goes into a small in-order queue, whatever the cache state, and a memory-side engine drains that queue one write at a time. On a store hit the cached bytes are updated as well. Memory therefore always receives every store, and a line is never dirty, so a miss never has to write a line back. A parameter decides what a store miss does. With allocation, the line is fetched first and the store then proceeds as a hit. Without allocation, the store only passes through the queue and the cache is left as it was.

Top module: `wt_cache`

## Requirements
- R1: The processor address is word aligned (bits 1:0 are zero). Bits 4:2 pick the word within a line, bits 9:5 pick one of 32 lines, and bits 31:10 are the tag. A request hits only when the indexed line is valid and its stored tag equals the address tag. Two addresses with the same index and different tags evict each other.
- R2: A read miss stalls the processor while the line refills. The refill is eight word reads at ascending addresses from the line base. The read is then answered with the refilled data.
- R3: A read hit returns its word combinationally in the accept cycle, with no stall and no memory access.
- R4: Each accepted store becomes exactly one memory write, in acceptance order. The write carries the word-aligned address, the store data and the byte enables. Once the queue has drained, memory holds every stored byte.
- R5: A store hit updates only the cached bytes whose enable bit is set (bit n covers data bits 8n+7:8n). It stalls only if the queue is full.
- R6: The store queue holds 4 entries. A store that arrives while 4 entries wait stalls until the head write is acknowledged.
- R7: With WRITE_ALLOC=1, a store miss first refills the line with eight reads and then completes as a store hit. A later read of that line hits.
- R8: With WRITE_ALLOC=0, a store miss issues no memory read and does not install the line. A later read of that line misses and refills.
- R9: A refill starts only when the store queue is empty, so refilled data already includes every earlier store.
- R10: After reset no line is valid, the store queue is empty and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_be | input | 4 | Byte enables of a store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid in the accept cycle |
| cpu_stall | output | 1 | Request not accepted this cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write from queue, 0 = refill read |
| mem_addr | output | 32 | Word address of the memory access |
| mem_be | output | 4 | Byte enables of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled with the acknowledge |
| mem_ack | input | 1 | Completes the current memory access |

## Verification
Two functions can fall in the same cycle: a store being accepted into the queue and the head entry retiring to memory, and with them the release of a full-queue stall on the very edge where the acknowledge frees a slot. A slow memory model provokes this. Four back-to-back stores fill the queue, and the fifth must then stall for exactly the cycles until the first acknowledge. Random mixes of reads and stores make pushes and pops meet on many edges. Every read value, every refill count and the final memory image are compared against a bench model of memory contents and line state.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int AW          = 32,
  parameter int LINE_BYTES  = 32,
  parameter int LINES       = 32,
  parameter int WB_DEPTH    = 4,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [3:0]    cpu_be,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - OFF_W - IDX_W;
  localparam int WPL   = LINE_BYTES / 4;
  localparam int WS_W  = OFF_W - 2;
  localparam int PTR_W = $clog2(WB_DEPTH);

  logic [31:0]      data_q [LINES*WPL];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q;

  logic             filling;
  logic [WS_W-1:0]  fill_cnt;
  logic [TAG_W-1:0] fill_tag;
  logic [IDX_W-1:0] fill_idx;

  logic [AW-3:0]    wb_a [WB_DEPTH];
  logic [31:0]      wb_d [WB_DEPTH];
  logic [3:0]       wb_b [WB_DEPTH];
  logic [PTR_W-1:0] wb_wp, wb_rp;
  logic [PTR_W:0]   wb_cnt;

  wire [IDX_W-1:0] idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  wire [WS_W-1:0]  wsel = cpu_addr[OFF_W-1:2];
  wire [TAG_W-1:0] atag = cpu_addr[AW-1:OFF_W+IDX_W];
  wire hit        = valid_q[idx] && (tag_q[idx] == atag);
  wire wb_empty   = (wb_cnt == '0);
  wire wb_full    = (wb_cnt == (PTR_W+1)'(WB_DEPTH));
  wire need_fill  = cpu_req && !hit && (!cpu_we || WRITE_ALLOC);
  wire fill_start = need_fill && !filling && wb_empty;
  wire wb_push    = cpu_req && cpu_we && !cpu_stall;
  wire wb_pop     = !filling && !wb_empty && mem_ack;
  wire fill_beat  = filling && mem_ack;
  wire fill_last  = fill_beat && (fill_cnt == WS_W'(WPL-1));

  assign cpu_stall = cpu_req && (filling || need_fill || (cpu_we && wb_full));
  assign cpu_rdata = data_q[{idx, wsel}];

  assign mem_req   = filling || !wb_empty;
  assign mem_we    = !filling;
  assign mem_addr  = filling ? {fill_tag, fill_idx, fill_cnt, 2'b00} : {wb_a[wb_rp], 2'b00};
  assign mem_be    = filling ? 4'hF : wb_b[wb_rp];
  assign mem_wdata = wb_d[wb_rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      filling  <= 1'b0;
      fill_cnt <= '0;
      fill_tag <= '0;
      fill_idx <= '0;
    end else if (fill_start) begin
      filling      <= 1'b1;
      fill_cnt     <= '0;
      fill_tag     <= atag;
      fill_idx     <= idx;
      valid_q[idx] <= 1'b0;
    end else if (fill_beat) begin
      fill_cnt <= fill_cnt + WS_W'(1);
      if (fill_last) begin
        filling           <= 1'b0;
        valid_q[fill_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_beat) data_q[{fill_idx, fill_cnt}] <= mem_rdata;
    if (fill_last) tag_q[fill_idx] <= fill_tag;
    if (wb_push && hit)
      for (int b = 0; b < 4; b++)
        if (cpu_be[b]) data_q[{idx, wsel}][8*b +: 8] <= cpu_wdata[8*b +: 8];
    if (wb_push) begin
      wb_a[wb_wp] <= cpu_addr[AW-1:2];
      wb_d[wb_wp] <= cpu_wdata;
      wb_b[wb_wp] <= cpu_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_wp  <= '0;
      wb_rp  <= '0;
      wb_cnt <= '0;
    end else begin
      if (wb_push) wb_wp <= wb_wp + PTR_W'(1);
      if (wb_pop)  wb_rp <= wb_rp + PTR_W'(1);
      wb_cnt <= wb_cnt + (PTR_W+1)'(wb_push) - (PTR_W+1)'(wb_pop);
    end
  end

  // R1
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[1:0] == 2'b00));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= (PTR_W+1)'(WB_DEPTH));
  // R9
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filling) |-> $past(wb_empty));
  // R2
  fill_reads_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> (mem_req && !mem_we));
  // R2
  fill_stalls_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filling && cpu_req) |-> cpu_stall);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: tb/sim_wt_cache.sv
`timescale 1ns/1ps

function automatic logic [31:0] seed_word(int i);
  return {i[15:0] ^ 16'h5A3C, i[15:0] + 16'h1357};
endfunction

module sim_mem #(parameter int LAT = 3, parameter int WORDS = 4096, parameter int LOGN = 1024) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack,
  output int          rd_cnt
);
  logic [31:0] mem [WORDS];
  logic        we_log [LOGN];
  logic [31:0] a_log  [LOGN];
  int cnt, n_log;
  assign ack   = req && (cnt == LAT);
  assign rdata = mem[addr[13:2]];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; n_log <= 0; rd_cnt <= 0;
      for (int i = 0; i < WORDS; i++) mem[i] <= seed_word(i);
    end else if (req && !ack) cnt <= cnt + 1;
    else begin
      cnt <= 0;
      if (ack) begin
        if (we) begin
          for (int b = 0; b < 4; b++) if (be[b]) mem[addr[13:2]][8*b +: 8] <= wdata[8*b +: 8];
        end else rd_cnt <= rd_cnt + 1;
        if (n_log < LOGN) begin
          we_log[n_log] <= we; a_log[n_log] <= addr; n_log <= n_log + 1;
        end
      end
    end
  end
endmodule

module sim_wt_cache;
  logic clk = 1'b0, rst_n;
  always #2.5 clk = ~clk;

  logic [1:0]  c_req, c_we, c_st, m_req, m_we, m_ack;
  logic [31:0] c_addr [2], c_wd [2], c_rd [2], m_addr [2], m_wd [2], m_rd [2];
  logic [3:0]  c_be [2], m_be [2];
  int          rdcnt [2];
  logic [31:0] rm [2][4096];
  bit          rv [2][32];
  logic [21:0] rt [2][32];
  int errs, checks;

  wt_cache #(.WRITE_ALLOC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
    .cpu_be(c_be[0]), .cpu_wdata(c_wd[0]), .cpu_rdata(c_rd[0]), .cpu_stall(c_st[0]),
    .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_be(m_be[0]),
    .mem_wdata(m_wd[0]), .mem_rdata(m_rd[0]), .mem_ack(m_ack[0]));
  wt_cache #(.WRITE_ALLOC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
    .cpu_be(c_be[1]), .cpu_wdata(c_wd[1]), .cpu_rdata(c_rd[1]), .cpu_stall(c_st[1]),
    .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_be(m_be[1]),
    .mem_wdata(m_wd[1]), .mem_rdata(m_rd[1]), .mem_ack(m_ack[1]));
  sim_mem m0 (.clk(clk), .rst_n(rst_n), .req(m_req[0]), .we(m_we[0]), .addr(m_addr[0]), .be(m_be[0]),
              .wdata(m_wd[0]), .rdata(m_rd[0]), .ack(m_ack[0]), .rd_cnt(rdcnt[0]));
  sim_mem m1 (.clk(clk), .rst_n(rst_n), .req(m_req[1]), .we(m_we[1]), .addr(m_addr[1]), .be(m_be[1]),
              .wdata(m_wd[1]), .rdata(m_rd[1]), .ack(m_ack[1]), .rd_cnt(rdcnt[1]));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic do_op(input int d, input bit we, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output int stl, output logic [31:0] rd);
    logic [4:0]  ix = a[9:5];
    logic [21:0] tg = a[31:10];
    bit hit = rv[d][ix] && (rt[d][ix] == tg);
    int exp_fill = (!hit && (!we || d == 0)) ? 8 : 0;
    int r0;
    string lbl;
    if (!we) lbl = hit ? "R3" : "R2";
    else lbl = hit ? "R5" : (d == 0 ? "R7" : "R8");
    @(negedge clk);
    r0 = rdcnt[d];
    c_req[d] = 1'b1; c_we[d] = we; c_addr[d] = a; c_be[d] = be; c_wd[d] = wd;
    #1;
    stl = 0;
    while (c_st[d]) begin
      @(negedge clk); #1; stl++;
    end
    rd = c_rd[d];
    check(lbl, rdcnt[d] - r0, exp_fill);
    if (!we) check("R1", rd, rm[d][a[13:2]]);
    @(posedge clk);
    if (exp_fill != 0) begin rv[d][ix] = 1'b1; rt[d][ix] = tg; end
    if (we) for (int b = 0; b < 4; b++) if (be[b]) rm[d][a[13:2]][8*b +: 8] = wd[8*b +: 8];
  endtask

  task automatic drain(input int d);
    @(negedge clk);
    c_req[d] = 1'b0;
    for (int i = 0; i < 400 && m_req[d]; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog R2 actual=hung expected=completion");
    summary();
    $finish;
  end

  initial begin
    int s, st5;
    logic [31:0] r, e;
    errs = 0; checks = 0; rst_n = 1'b0;
    c_req = '0; c_we = '0;
    for (int d = 0; d < 2; d++) begin
      c_addr[d] = '0; c_wd[d] = '0; c_be[d] = '0;
      for (int i = 0; i < 4096; i++) rm[d][i] = seed_word(i);
      for (int i = 0; i < 32; i++) begin rv[d][i] = 1'b0; rt[d][i] = '0; end
    end
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10", {30'd0, m_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10", {30'd0, m_req}, 32'd0);
    check("R10", {30'd0, c_st}, 32'd0);

    // R2 first access after reset misses and refills from the line base upward
    do_op(0, 1'b0, 32'h124, 4'h0, 0, s, r);
    for (int k = 0; k < 8; k++) begin
      check("R2", m0.a_log[k], 32'h120 + 4*k);
      check("R2", {31'd0, m0.we_log[k]}, 32'd0);
    end
    do_op(0, 1'b0, 32'h13C, 4'h0, 0, s, r);
    check("R3", s, 0);
    do_op(0, 1'b1, 32'h120, 4'b0110, 32'hDEADBEEF, s, r);
    check("R5", s, 0);
    do_op(0, 1'b1, 32'h128, 4'hF, 32'h11223344, s, r);
    check("R5", s, 0);
    do_op(0, 1'b1, 32'h130, 4'b0001, 32'hAABBCCDD, s, r);
    check("R5", s, 0);
    // R1 conflicting tag on the same index; R9 queue drains before refill
    do_op(0, 1'b0, 32'h524, 4'h0, 0, s, r);
    check("R4", m0.a_log[8], 32'h120);
    check("R4", m0.a_log[9], 32'h128);
    check("R4", m0.a_log[10], 32'h130);
    check("R4", {31'd0, m0.we_log[10]}, 32'd1);
    check("R9", m0.a_log[11], 32'h520);
    check("R9", {31'd0, m0.we_log[11]}, 32'd0);
    do_op(0, 1'b0, 32'h124, 4'h0, 0, s, r);
    do_op(0, 1'b0, 32'h120, 4'h0, 0, s, r);
    e = (seed_word(32'h120 >> 2) & 32'hFF0000FF) | (32'hDEADBEEF & 32'h00FFFF00);
    check("R5", r, e);
    // R7 allocating store miss
    do_op(0, 1'b1, 32'h840, 4'b1000, 32'h5A000000, s, r);
    do_op(0, 1'b0, 32'h840, 4'h0, 0, s, r);
    check("R7", s, 0);
    drain(0);

    // R8 non-allocating store miss, then R9 on the following read miss
    do_op(1, 1'b1, 32'h200, 4'hF, 32'hCAFEF00D, s, r);
    check("R8", s, 0);
    do_op(1, 1'b0, 32'h200, 4'h0, 0, s, r);
    check("R8", r, 32'hCAFEF00D);
    check("R9", m1.a_log[0], 32'h200);
    check("R9", {31'd0, m1.we_log[0]}, 32'd1);
    check("R9", m1.a_log[1], 32'h200);
    check("R9", {31'd0, m1.we_log[1]}, 32'd0);
    drain(1);
    // R6 five back-to-back stores against a 4-entry queue
    for (int k = 0; k < 4; k++) begin
      do_op(1, 1'b1, 32'h600 + 32'h40*k, 4'hF, 32'h1000 + k, s, r);
      check("R6", s, 0);
    end
    do_op(1, 1'b1, 32'h700, 4'hF, 32'h2000, st5, r);
    check("R6", st5, 1);
    drain(1);

    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 400; n++) begin
        logic [31:0] a = '0;
        bit we = $urandom % 2;
        logic [3:0] be = 4'($urandom % 15 + 1);
        a[11:10] = 2'($urandom); a[7:5] = 3'($urandom); a[4:2] = 3'($urandom);
        do_op(d, we, a, be, $urandom, s, r);
        if ($urandom % 4 == 0) begin @(negedge clk); c_req[d] = 1'b0; end
      end
      drain(d);
    end

    begin
      int bad = 0;
      for (int i = 0; i < 4096; i++) begin
        if (m0.mem[i] !== rm[0][i]) bad++;
        if (m1.mem[i] !== rm[1][i]) bad++;
      end
      check("R4", bad, 0);
    end
    summary();
    $finish;
  end
endmodule